// File: doc/BRIEF.md
# Multichannel Cycle-Stealing Block Transfer Engine

The engine moves blocks of words between peripherals and memory without the processor touching each word. It has eight channels. Each channel keeps the memory address of its next word and the number of words still to move. The processor loads both through a small register write port. A peripheral raises its channel's word request, and the engine chooses one requesting channel. It then takes one memory cycle through a request/grant handshake with the memory port, moves a single word and acknowledges the device. After that it steps that channel's address up and its count down, and arbitrates again. Because only one word moves per stolen cycle, several channels interleave their blocks word by word.

A channel moves data in one of two directions, chosen per request by the device's direction pin: device into memory (a memory write) or memory out to the device (a memory read). When a block ends, the channel raises a done flag and stops. The processor can instead preload a chained block, a second address and count. The channel then moves straight into the chained block without software help and signals done only when that block also ends.

Top module: `cs_xfer_engine`

## Requirements
- R1: After synchronous active-low reset, `mem_req` is low, all `dev_ack` bits are low, all `done` bits are low and every channel count is zero (inactive).
- R2: A request on a channel whose word count is zero is ignored: no memory request is raised and that channel is never acknowledged.
- R3: When several active channels request at once, the lowest-numbered one is served first. Arbitration repeats after every single word, so channel 1 finishes all its words before channel 4 starts, and channel 4 before channel 6.
- R4: Each stolen cycle moves exactly one word. `mem_req` rises one cycle after arbitration, stays high until `mem_gnt`, falls the cycle after the grant, and exactly one `dev_ack` bit is high for that one following cycle.
- R5: With `dev_dir[i]`=1 (memory to device) the engine reads (`mem_we`=0), and `dev_rdata` during the acknowledge cycle holds the word memory returned at the grant. With `dev_dir[i]`=0 (device to memory) the engine writes (`mem_we`=1) with `mem_wdata` taken from the channel's 16-bit slice `dev_wdata[16*i +: 16]`.
- R6: Successive words of a block go to consecutive addresses, starting at the loaded address, and exactly as many words move as the loaded count.
- R7: When the count reaches zero and no chained block is armed, `done[i]` rises in the acknowledge cycle of the last word. Further requests on that channel are then ignored.
- R8: With a chained block armed (configuration select 3 writes the chained count and arms it; select 2 writes the chained address), the word that empties the count reloads address and count from the chained registers and disarms chaining. `done[i]` stays low until the chained block ends.
- R9: Configuration select 0 writes a channel's address and select 1 writes its count. A count write clears that channel's `done` bit on the following cycle and, if nonzero, makes the channel active.
- R10: While `mem_req` waits for `mem_gnt`, `mem_addr` holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 3 | Channel addressed by the write |
| cfg_sel | input | 2 | 0 address, 1 count, 2 chained address, 3 chained count (arms chaining) |
| cfg_data | input | 16 | Write data |
| dev_req | input | 8 | Per-channel word request |
| dev_dir | input | 8 | Per-channel direction, 1 = memory to device |
| dev_wdata | input | 128 | Per-channel device data, 16 bits per channel |
| dev_ack | output | 8 | Per-channel one-cycle word acknowledge |
| dev_rdata | output | 16 | Word read from memory, valid with the acknowledge |
| mem_req | output | 1 | Memory cycle request |
| mem_gnt | input | 1 | Memory cycle grant |
| mem_addr | output | 16 | Memory word address |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with the grant |
| done | output | 8 | Per-channel block-finished flag |

## Verification
Every channel is swept with block lengths of one to three words, with grant latencies of zero to two cycles. This separates address stepping and count termination from handshake waiting. Both directions are run, so read-data return and write-data selection are told apart from each other. Three channels requesting at once expose the priority order and the per-word arbitration. A chained block, followed by a rerun of the same channel, shows both the reload and the one-shot clearing of the chain arm. Requests on unloaded or finished channels must produce no memory cycle at all.

// File: rtl/cs_xfer_pkg.sv
// Shared definitions for the cycle-stealing transfer engine.
// Assumes: nothing beyond IEEE 1800-2017.
package cs_xfer_pkg;

    // Sequencer states: choose a channel, hold the memory request, acknowledge
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACK  = 2'd2
    } xfer_state_t;

    // Configuration register selects
    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_CADDR  = 2'd2;
    localparam logic [1:0] SEL_CCOUNT = 2'd3;

endpackage

// File: rtl/cs_chan_slot.sv
// One channel's state: next address, remaining count, chained block, done flag.
// Assumes: step is asserted only while the channel is active; a configuration
// write and a step in the same cycle resolve in favour of the write.
module cs_chan_slot
    import cs_xfer_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             step,
    output logic [REG_W-1:0] addr,
    output logic             active,
    output logic             done
);

    logic [REG_W-1:0] count;
    logic [REG_W-1:0] chain_addr;
    logic [REG_W-1:0] chain_count;
    logic             chain_arm;
    logic             last_word;

    assign active    = (count != '0);
    assign last_word = (count == REG_W'(1));

    // Register loads from the processor and per-word advance with optional chaining
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr        <= '0;
            count       <= '0;
            chain_addr  <= '0;
            chain_count <= '0;
            chain_arm   <= 1'b0;
            done        <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ADDR:   addr <= wr_data;
                SEL_COUNT: begin
                    count <= wr_data;
                    done  <= 1'b0;
                end
                SEL_CADDR:  chain_addr <= wr_data;
                default: begin
                    chain_count <= wr_data;
                    chain_arm   <= 1'b1;
                end
            endcase
        end else if (step) begin
            if (last_word && chain_arm) begin
                addr      <= chain_addr;
                count     <= chain_count;
                chain_arm <= 1'b0;
                done      <= (chain_count == '0);
            end else begin
                addr  <= addr + REG_W'(1);
                count <= count - REG_W'(1);
                done  <= last_word;
            end
        end
    end

endmodule

// File: rtl/cs_prio_pick.sv
// Fixed-priority selector: lowest-numbered asserted bit wins.
// Assumes: IDX_W is wide enough to hold NCH-1.
module cs_prio_pick #(
    parameter int NCH   = 8,
    parameter int IDX_W = 3
) (
    input  logic [NCH-1:0]   cand,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top down so the lowest index is the last to overwrite
    always_comb begin
        hit = |cand;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cand[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/cs_xfer_engine.sv
// Multichannel cycle-stealing block transfer engine (top).
// Picks one eligible channel, holds a memory request until granted, moves one
// word, acknowledges the device for one cycle, then arbitrates again.
// Assumes: devices hold dev_dir and dev_wdata stable while their request is
// pending; memory returns read data in the grant cycle.
module cs_xfer_engine
    import cs_xfer_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int REG_W = 16,
    parameter int DW    = 16,
    parameter int CHW   = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_data,
    input  logic [NCH-1:0]    dev_req,
    input  logic [NCH-1:0]    dev_dir,
    input  logic [NCH*DW-1:0] dev_wdata,
    output logic [NCH-1:0]    dev_ack,
    output logic [DW-1:0]     dev_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [REG_W-1:0]  mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [NCH-1:0]    done
);

    xfer_state_t      state;
    logic [CHW-1:0]   win;
    logic [DW-1:0]    rd_q;
    logic [NCH-1:0]   active_vec;
    logic [NCH-1:0]   step_vec;
    logic [NCH-1:0]   eligible;
    logic             pick_hit;
    logic [CHW-1:0]   pick_idx;
    logic [REG_W-1:0] addr_arr [NCH];

    // Per-channel register slots
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        assign step_vec[g] = (state == ST_REQ) && mem_gnt && (win == CHW'(g));
        assign dev_ack[g]  = (state == ST_ACK) && (win == CHW'(g));

        cs_chan_slot #(.REG_W(REG_W)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_ch == CHW'(g))),
            .wr_sel  (cfg_sel),
            .wr_data (cfg_data),
            .step    (step_vec[g]),
            .addr    (addr_arr[g]),
            .active  (active_vec[g]),
            .done    (done[g])
        );
    end

    assign eligible = dev_req & active_vec;

    cs_prio_pick #(.NCH(NCH), .IDX_W(CHW)) u_pick (
        .cand (eligible),
        .hit  (pick_hit),
        .idx  (pick_idx)
    );

    // Sequencer: arbitrate, steal one memory cycle, acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            win   <= '0;
            rd_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (pick_hit) begin
                    win   <= pick_idx;
                    state <= ST_REQ;
                end
                ST_REQ: if (mem_gnt) begin
                    rd_q  <= mem_rdata;
                    state <= ST_ACK;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ST_REQ);
    assign mem_addr  = addr_arr[win];
    assign mem_we    = ~dev_dir[win];
    assign mem_wdata = dev_wdata[int'(win)*DW +: DW];
    assign dev_rdata = rd_q;

endmodule

// File: rtl/cs_xfer_engine_chk.sv
// Protocol checker for the transfer engine, attached by bind.
// Assumes: synchronous active-low reset on the same clock.
module cs_xfer_engine_chk #(
    parameter int NCH   = 8,
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mem_req,
    input logic             mem_gnt,
    input logic [REG_W-1:0] mem_addr,
    input logic [NCH-1:0]   dev_ack
);

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack)); // R4

    AST_ACK_FOLLOWS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> ($countones(dev_ack) == 1)); // R4

    AST_REQ_DROPS_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req); // R4

    AST_NO_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != '0) |-> !mem_req); // R4

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr))); // R10

endmodule

bind cs_xfer_engine cs_xfer_engine_chk #(.NCH(NCH), .REG_W(REG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .dev_ack  (dev_ack)
);

// File: tb/cs_xfer_engine_tb.sv
// Self-checking bench: memory and device models, block sweeps over every channel.
module cs_xfer_engine_tb;

    localparam int NCH = 8;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_ch = '0;
    logic [1:0]        cfg_sel = '0;
    logic [15:0]       cfg_data = '0;
    logic [NCH-1:0]    dev_req = '0;
    logic [NCH-1:0]    dev_dir = '0;
    logic [NCH*DW-1:0] dev_wdata;
    logic [NCH-1:0]    dev_ack;
    logic [15:0]       dev_rdata;
    logic              mem_req;
    logic              mem_gnt = 1'b0;
    logic [15:0]       mem_addr;
    logic              mem_we;
    logic [15:0]       mem_wdata;
    logic [15:0]       mem_rdata;
    logic [NCH-1:0]    done;

    int checks = 0;
    int failures = 0;
    int gnt_delay = 0;
    int wcnt = 0;
    int nlog = 0;
    int nack = 0;
    bit seen_req = 1'b0;
    logic [15:0] want [NCH];
    logic [15:0] log_addr [512];
    logic        log_we [512];
    logic [15:0] log_wdata [512];
    int          ack_ch [512];
    logic        ack_done [512];
    logic [15:0] rd_expect = '0;

    always #2 clk = ~clk;

    cs_xfer_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .dev_req(dev_req),
        .dev_dir(dev_dir), .dev_wdata(dev_wdata), .dev_ack(dev_ack),
        .dev_rdata(dev_rdata), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done)
    );

    assign mem_rdata = mem_addr ^ 16'hA5A5;

    always_comb begin
        for (int c = 0; c < NCH; c++)
            dev_wdata[c*DW +: DW] = {4'(c), want[c][11:0]};
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory and device models, evaluated away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) seen_req = 1'b1;
            if (mem_gnt) begin
                mem_gnt = 1'b0;
                wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= gnt_delay) begin
                    mem_gnt = 1'b1;
                    log_addr[nlog] = mem_addr;
                    log_we[nlog] = mem_we;
                    log_wdata[nlog] = mem_wdata;
                    rd_expect = mem_rdata;
                    nlog++;
                end else begin
                    wcnt++;
                end
            end
            for (int c = 0; c < NCH; c++) begin
                if (dev_ack[c]) begin
                    ack_ch[nack] = c;
                    ack_done[nack] = done[c];
                    if (dev_dir[c])
                        check(dev_rdata == rd_expect, "R5", "read data",
                              int'(dev_rdata), int'(rd_expect));
                    if (want[c] != 0) want[c] = want[c] - 1;
                    nack++;
                end
            end
            for (int c = 0; c < NCH; c++) dev_req[c] = (want[c] != 0);
        end
    end

    task automatic cfg(input int ch, input int sel, input int data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_ch = 3'(ch);
        cfg_sel = 2'(sel);
        cfg_data = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_acks(input int n);
        for (int k = 0; k < 3000 && nack < n; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_xfer(input int ch, input int base, input int cnt,
                            input bit dir, input int dly);
        int s_log, s_ack;
        s_log = nlog;
        s_ack = nack;
        gnt_delay = dly;
        cfg(ch, 0, base);
        cfg(ch, 1, cnt);
        dev_dir[ch] = dir;
        want[ch] = 16'(cnt);
        wait_acks(s_ack + cnt);
        check(nlog - s_log == cnt, "R6", "word count", nlog - s_log, cnt);
        for (int k = 0; k < cnt; k++) begin
            check(log_addr[s_log+k] == 16'(base + k), "R6", "address",
                  int'(log_addr[s_log+k]), base + k);
            check(log_we[s_log+k] == !dir, "R5", "write enable",
                  int'(log_we[s_log+k]), int'(!dir));
            if (!dir)
                check(log_wdata[s_log+k] == {4'(ch), 12'(cnt - k)}, "R5",
                      "write data", int'(log_wdata[s_log+k]),
                      int'({4'(ch), 12'(cnt - k)}));
            check(ack_ch[s_ack+k] == ch, "R4", "acked channel",
                  ack_ch[s_ack+k], ch);
            check(ack_done[s_ack+k] == (k == cnt - 1), "R7", "done timing",
                  int'(ack_done[s_ack+k]), int'(k == cnt - 1));
        end
        check(done[ch] == 1'b1, "R7", "done set", int'(done[ch]), 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int s_log, s_ack;
        for (int c = 0; c < NCH; c++) want[c] = '0;
        repeat (5) @(negedge clk);
        check(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
        check(dev_ack == '0, "R1", "ack after reset", int'(dev_ack), 0);
        check(done == '0, "R1", "done after reset", int'(done), 0);

        // R2: requests on unloaded channels
        seen_req = 1'b0;
        want[3] = 2;
        want[7] = 1;
        repeat (20) @(negedge clk);
        check(seen_req == 1'b0, "R2", "memory request on idle channel",
              int'(seen_req), 0);
        check(nack == 0, "R2", "acks on idle channel", nack, 0);
        want[3] = 0;
        want[7] = 0;
        repeat (2) @(negedge clk);

        // Directed single runs: output and input directions, with waits
        run_xfer(2, 16'h0040, 4, 1'b1, 2);
        run_xfer(5, 16'h0080, 3, 1'b0, 1);

        // R7: finished channel ignores further requests
        s_log = nlog;
        s_ack = nack;
        want[2] = 1;
        repeat (20) @(negedge clk);
        check(nlog == s_log, "R7", "cycles after done", nlog - s_log, 0);
        check(nack == s_ack, "R7", "acks after done", nack - s_ack, 0);
        want[2] = 0;
        repeat (2) @(negedge clk);

        // R9: count write clears done
        cfg(2, 0, 16'h0050);
        cfg(2, 1, 2);
        check(done[2] == 1'b0, "R9", "done cleared by count write",
              int'(done[2]), 0);
        s_log = nlog;
        dev_dir[2] = 1'b1;
        want[2] = 2;
        wait_acks(nack + 2);
        check(log_addr[s_log] == 16'h0050 && log_addr[s_log+1] == 16'h0051,
              "R9", "rearmed addresses", int'(log_addr[s_log]), 16'h0050);

        // R3: simultaneous requests, lowest channel first, per-word arbitration
        gnt_delay = 1;
        cfg(1, 0, 16'h0010); cfg(1, 1, 2);
        cfg(4, 0, 16'h0030); cfg(4, 1, 2);
        cfg(6, 0, 16'h0060); cfg(6, 1, 2);
        dev_dir = '1;
        s_ack = nack;
        s_log = nlog;
        want[1] = 2; want[4] = 2; want[6] = 2;
        wait_acks(s_ack + 6);
        for (int k = 0; k < 6; k++) begin
            int exp_ch;
            exp_ch = (k < 2) ? 1 : ((k < 4) ? 4 : 6);
            check(ack_ch[s_ack+k] == exp_ch, "R3", "service order",
                  ack_ch[s_ack+k], exp_ch);
        end
        check(log_addr[s_log+2] == 16'h0030, "R3", "third cycle address",
              int'(log_addr[s_log+2]), 16'h0030);

        // R8: chained block
        gnt_delay = 0;
        cfg(0, 2, 16'h00A0);
        cfg(0, 3, 3);
        cfg(0, 0, 16'h0020);
        cfg(0, 1, 2);
        s_ack = nack;
        s_log = nlog;
        want[0] = 5;
        wait_acks(s_ack + 5);
        check(nlog - s_log == 5, "R8", "chained word count", nlog - s_log, 5);
        for (int k = 0; k < 5; k++) begin
            int ea;
            ea = (k < 2) ? (16'h0020 + k) : (16'h00A0 + k - 2);
            check(log_addr[s_log+k] == 16'(ea), "R8", "chained address",
                  int'(log_addr[s_log+k]), ea);
            check(ack_done[s_ack+k] == (k == 4), "R8", "done only at chain end",
                  int'(ack_done[s_ack+k]), int'(k == 4));
        end
        // R8: chaining disarmed after use, next block ends normally
        run_xfer(0, 16'h0020, 1, 1'b1, 0);

        // Sweep: every channel, lengths 1..3, both directions, grant waits 0..2
        for (int c = 0; c < NCH; c++) begin
            for (int n = 1; n <= 3; n++) begin
                run_xfer(c, 16'h0100 + c * 16 + n * 4, n, 1'((c + n) % 2), (c + n) % 3);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule